// File: doc/BRIEF.md
# Single-Wire Bus Slot Engine

This block generates the elementary time slots of an open-drain single-wire bus. It can issue a bus reset with presence detection, a write slot carrying one bit, and a read slot that samples one bit. The bus side is a single drive-low enable and a raw line input. The raw input is resynchronised inside the block before it is sampled. A controller higher up builds bytes and transactions by issuing one slot command at a time and collecting the result on the done pulse.

Every duration is written in microseconds and converted to clock cycles. The conversion multiplies by the `CLK_PER_US` parameter and by a runtime scale input. The scale lets slow or heavily loaded buses stretch all slot timing together. The scale is captured when a command is accepted, so it may change freely while a slot runs.

Top module: `owb_slot_engine`

## Requirements
- R1: With scale value s (s = 0 acts as 1) and m = s * CLK_PER_US, a write slot (kind 1) with bit 1 drives the line low for 6*m cycles. It then releases the line and asserts done 70*m cycles after the accepting edge, with result 0.
- R2: A write slot (kind 1) with bit 0 drives the line low for 60*m cycles and asserts done 70*m cycles after the accepting edge, with result 0.
- R3: A read slot (kind 2) drives the line low for 6*m cycles. It samples the synchronised line 9*m cycles after release and asserts done 70*m cycles after the accepting edge. The result is the sampled level.
- R4: A reset slot (kind 0) drives the line low for 500*m cycles and samples the line 70*m cycles after release. It asserts done 1000*m cycles after the accepting edge (a 430*m cycle tail after the sample). The result is 0 when the line was low (device present) and 1 when it was high.
- R5: A touch slot (kind 3) with bit 1 behaves exactly as a read slot. With bit 0 it behaves exactly as a write-0 slot and returns 0.
- R6: All durations scale with the scale input value captured at the accepting edge. A value of 0 is treated as 1, and changing the input during a slot has no effect on that slot.
- R7: A command is accepted at a rising edge where cmd_valid is high and busy is low. Busy is then high from the following cycle until the done cycle. A command presented while busy is ignored.
- R8: Done is high for exactly one clock, and result is valid in that cycle. In the done cycle busy is low, so a command held on cmd_valid is accepted at the next edge.
- R9: After reset the block is idle: busy, done and bus_drive_low are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | Slot kind: 0 reset, 1 write, 2 read, 3 touch |
| cmd_bit | input | 1 | Bit for write and touch slots |
| scale | input | SCALE_W | Timing multiplier, 0 treated as 1 |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Sampled bit or presence result, valid with done |
| bus_drive_low | output | 1 | Pull the bus line low when high |
| bus_in | input | 1 | Raw bus line level |

## Verification
Two events can share a cycle: a slot completing (done high, busy low) and a new command on cmd_valid. The bench holds cmd_valid high across a completion. It then checks that done lasts one cycle and that the next slot starts at the edge right after it, with busy and the low drive both visible in the next cycle. A competing command with a different kind and scale is also injected early in every slot. The slot timing, the low width and the result must match the values computed for the original command.

// File: rtl/owb_pkg.sv
package owb_pkg;

    typedef enum logic [1:0] {
        K_RESET = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2,
        K_TOUCH = 2'd3
    } owb_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_GAP,
        PH_TAIL
    } owb_phase_e;

    localparam int unsigned US_W         = 10;
    localparam int unsigned MAX_PHASE_US = 500;

    // part of a slot that follows the low phase
    typedef struct packed {
        logic [US_W-1:0] gap_us;
        logic [US_W-1:0] tail_us;
        logic            sample;
    } owb_rest_t;

    typedef struct packed {
        logic [US_W-1:0] low_us;
        owb_rest_t       rest;
    } owb_profile_t;

    function automatic owb_profile_t mk_prof(int unsigned lo, int unsigned ga,
                                             int unsigned ta, logic smp);
        owb_profile_t p;
        p.low_us       = US_W'(lo);
        p.rest.gap_us  = US_W'(ga);
        p.rest.tail_us = US_W'(ta);
        p.rest.sample  = smp;
        return p;
    endfunction

    function automatic owb_profile_t slot_profile(owb_kind_e k, logic b);
        owb_profile_t p;
        case (k)
            K_RESET: p = mk_prof(500, 70, 430, 1'b1);
            K_WRITE: p = b ? mk_prof(6, 64, 0, 1'b0) : mk_prof(60, 10, 0, 1'b0);
            K_READ:  p = mk_prof(6, 9, 55, 1'b1);
            default: p = b ? mk_prof(6, 9, 55, 1'b1) : mk_prof(60, 10, 0, 1'b0);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/owb_sync2.sv
module owb_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/owb_phase_timer.sv
module owb_phase_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/owb_slot_ctrl.sv
module owb_slot_ctrl
    import owb_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned SCALE_W    = 4,
    parameter int unsigned CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic               cmd_bit,
    input  logic [SCALE_W-1:0] scale,
    input  logic               line_sync,
    input  logic               tmr_expired,
    output logic               tmr_load,
    output logic [CNT_W-1:0]   tmr_val,
    output logic               busy,
    output logic               done,
    output logic               result,
    output logic               drive_low
);
    owb_phase_e         phase;
    owb_rest_t          rest_q;
    logic [SCALE_W-1:0] scl_q;
    logic               res_q;
    logic               done_q;

    owb_profile_t       in_prof;
    logic [SCALE_W-1:0] in_scl;
    logic               accept;
    logic [US_W-1:0]    ld_us;
    logic [SCALE_W-1:0] ld_scl;
    logic [31:0]        ld_cyc;

    assign accept  = cmd_valid && (phase == PH_IDLE);
    assign in_prof = slot_profile(owb_kind_e'(cmd_kind), cmd_bit);
    assign in_scl  = (scale == '0) ? SCALE_W'(1) : scale;

    always_comb begin
        tmr_load = 1'b0;
        ld_us    = '0;
        ld_scl   = scl_q;
        case (phase)
            PH_IDLE: if (accept) begin
                tmr_load = 1'b1;
                ld_us    = in_prof.low_us;
                ld_scl   = in_scl;
            end
            PH_LOW: if (tmr_expired) begin
                tmr_load = 1'b1;
                ld_us    = rest_q.gap_us;
            end
            PH_GAP: if (tmr_expired && rest_q.tail_us != '0) begin
                tmr_load = 1'b1;
                ld_us    = rest_q.tail_us;
            end
            default: ;
        endcase
        ld_cyc  = 32'(ld_us) * 32'(ld_scl) * 32'(CLK_PER_US);
        tmr_val = CNT_W'(ld_cyc - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            rest_q <= '0;
            scl_q  <= SCALE_W'(1);
            res_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: if (accept) begin
                    phase  <= PH_LOW;
                    rest_q <= in_prof.rest;
                    scl_q  <= in_scl;
                    res_q  <= 1'b0;
                end
                PH_LOW: if (tmr_expired) phase <= PH_GAP;
                PH_GAP: if (tmr_expired) begin
                    if (rest_q.sample) res_q <= line_sync;
                    if (rest_q.tail_us != '0) begin
                        phase <= PH_TAIL;
                    end else begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                PH_TAIL: if (tmr_expired) begin
                    phase  <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign drive_low = (phase == PH_LOW);
    assign done      = done_q;
    assign result    = res_q;
endmodule

// File: rtl/owb_slot_engine.sv
module owb_slot_engine
    import owb_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned SCALE_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic               cmd_bit,
    input  logic [SCALE_W-1:0] scale,
    output logic               busy,
    output logic               done,
    output logic               result,
    output logic               bus_drive_low,
    input  logic               bus_in
);
    localparam int unsigned MAX_CYC = MAX_PHASE_US * ((2 ** SCALE_W) - 1) * CLK_PER_US;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic             line_sync;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    owb_sync2 #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (line_sync)
    );

    owb_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    owb_slot_ctrl #(
        .CLK_PER_US (CLK_PER_US),
        .SCALE_W    (SCALE_W),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_bit     (cmd_bit),
        .scale       (scale),
        .line_sync   (line_sync),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .busy        (busy),
        .done        (done),
        .result      (result),
        .drive_low   (bus_drive_low)
    );
endmodule

// File: rtl/owb_slot_engine_chk.sv
module owb_slot_engine_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic bus_drive_low
);
    // R8: completion pulse lasts a single cycle
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done only follows a busy slot and arrives with busy low
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7: an accepted command starts a slot with the line pulled low
    a_r7_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> (busy && bus_drive_low));

    // R7: a slot ends only through done, never silently
    a_r7_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R7: no line drive while idle
    a_r7_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_drive_low);

    // R9: reset returns the block to idle
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !bus_drive_low));
endmodule

bind owb_slot_engine owb_slot_engine_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .busy          (busy),
    .done          (done),
    .bus_drive_low (bus_drive_low)
);

// File: tb/owb_slot_engine_tb_top.sv
module owb_slot_engine_tb_top;
    localparam int unsigned CPU = 2;
    localparam int unsigned SW  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = 2'd0;
    logic          cmd_bit = 1'b0;
    logic [SW-1:0] scale = '0;
    logic          busy, done, result, bus_drive_low;
    logic          dev_pull = 1'b0;
    logic          bus_line;

    int n_chk = 0;
    int n_bad = 0;

    assign bus_line = !(bus_drive_low || dev_pull);

    always #5 clk = ~clk;

    owb_slot_engine #(.CLK_PER_US(CPU), .SCALE_W(SW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_kind      (cmd_kind),
        .cmd_bit       (cmd_bit),
        .scale         (scale),
        .busy          (busy),
        .done          (done),
        .result        (result),
        .bus_drive_low (bus_drive_low),
        .bus_in        (bus_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one slot: kind k, bit b, scale s, device pulling the line around the sample point when pull=1
    task automatic run_slot(input int k, input bit b, input int s, input bit pull);
        int lo, ga, ta, es, mult, sp, cyc, lowc, busyc;
        bit is_read, is_reset, exp_res;
        string tag;
        is_reset = (k == 0);
        is_read  = (k == 2) || (k == 3 && b);
        if (is_reset)      begin lo = 500; ga = 70; ta = 430; end
        else if (is_read)  begin lo = 6;   ga = 9;  ta = 55;  end
        else if (b && k == 1) begin lo = 6; ga = 64; ta = 0; end
        else               begin lo = 60;  ga = 10; ta = 0;   end
        tag = is_reset ? "R4" : (k == 3 ? "R5" : (is_read ? "R3" : (b ? "R1" : "R2")));
        exp_res = (is_reset || is_read) ? !pull : 1'b0;
        es   = (s == 0) ? 1 : s;
        mult = es * CPU;
        sp   = (lo + ga) * mult;

        @(negedge clk);
        cmd_kind = 2'(k); cmd_bit = b; scale = SW'(s); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0; lowc = 0; busyc = 0;
        while (!done && cyc < 20000) begin
            if (bus_drive_low) lowc++;
            if (busy) busyc++;
            cyc++;
            if (cyc == 2) begin
                // competing command while busy: R7, scale change mid-slot: R6
                cmd_valid = 1'b1; cmd_kind = 2'(k + 1); cmd_bit = !b; scale = SW'(s + 1);
            end
            if (cyc == 4) cmd_valid = 1'b0;
            dev_pull = pull && (cyc >= sp - 6) && (cyc <= sp + 4);
            @(negedge clk);
        end
        chk(cyc < 20000, "watchdog", cyc, 20000);
        chk(lowc == lo * mult, {tag, " low width (R6)"}, lowc, lo * mult);
        chk(cyc == (lo + ga + ta) * mult, {tag, " done latency (R6 R7)"}, cyc, (lo + ga + ta) * mult);
        chk(busyc == cyc, "R7 busy span", busyc, cyc);
        chk(result == exp_res, {tag, " result (R8)"}, int'(result), int'(exp_res));
        dev_pull = 1'b0;
        @(negedge clk);
        chk(!done, "R8 done width", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_drive_low, "R9 reset state",
            int'({busy, done, bus_drive_low}), 0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 4; s++)
                    for (int p = 0; p < 2; p++)
                        run_slot(k, 1'(b), s, 1'(p));

        // R8: command held through a completion is accepted at the next edge
        @(negedge clk);
        cmd_kind = 2'd1; cmd_bit = 1'b1; scale = SW'(1); cmd_valid = 1'b1;
        begin
            int w = 0;
            @(negedge clk);
            while (!done && w < 20000) begin w++; @(negedge clk); end
            chk(w < 20000, "watchdog", w, 20000);
            chk(!busy, "R8 busy low in done cycle", int'(busy), 0);
            @(negedge clk);
            chk(busy && bus_drive_low && !done, "R8 back-to-back accept",
                int'({busy, bus_drive_low, done}), 6);
            cmd_valid = 1'b0;
            w = 0;
            while (!done && w < 20000) begin w++; @(negedge clk); end
            chk(w < 20000, "watchdog", w, 20000);
        end

        // R9: synchronous reset in the middle of a slot
        @(negedge clk);
        cmd_kind = 2'd0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_drive_low, "R9 reset mid-slot",
            int'({busy, done, bus_drive_low}), 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule